// File: doc/BRIEF.md
# I2C bus condition generator

This block sits between a byte shifter and the open-drain pads of a simple I2C master. Each of its two line outputs is an active-high pull-low enable. When an enable is 1 the line is pulled low. When it is 0 the line is released and the external pull-up brings it high.

A 2-bit selector per line picks one of four sources:
- the shifter's serial path;
- the condition generator;
- a constant low;
- a released (high-impedance) state.

When asked, the generator produces a start, a repeated start or a stop condition. Each step of a condition lasts a programmable number of clock cycles, and a sticky completion flag reports the end of the sequence. On the serial SDA path the block applies a programmable output delay, counted in ticks of a divided filter clock, so data changes lag the falling edge of SCL. During the ninth clock of a byte, the shifter's data is replaced by the acknowledge setting. The SDA value seen on the ninth rising SCL edge is captured as the received acknowledge bit.

Top module: `i2c_cond_gen`

## Requirements
- R1: After synchronous reset, `done_flag` and `ack_rx` are 0 and the generator releases both lines, so with both selectors at 01 `sda_oe` and `scl_oe` are 0.
- R2: A start request makes the generator, as {SDA pull-low, SCL pull-low}, drive 10 for one phase and then 11. Both lines then stay held until the next condition.
- R3: A stop request drives 10 for one phase and then 00. Both lines then stay released.
- R4: A restart request drives 01, then 00, then 10, then 11, one phase each.
- R5: Each phase lasts `half_period` clock cycles, and a value of 0 counts as 1. The first phase appears on the outputs right after the clock edge that samples the request.
- R6: `done_flag` becomes 1 on the edge that ends the last phase. It is 0 from the accepting edge through the whole sequence. After that it stays 1 until `done_clr` is sampled while idle. Completion on the same edge as `done_clr` leaves it set.
- R7: Requests arriving while a sequence runs are ignored. Simultaneous requests resolve with start first, then restart, then stop.
- R8: `sda_sel` encodes 00 = delayed serial path, 01 = generator, 10 = pull low (`sda_oe`=1), 11 = released (`sda_oe`=0). On the serial path `sda_oe` is the inverse of `sh_sda`.
- R9: `scl_sel` uses the same encoding, with `scl_oe` = inverse of `sh_scl` on the serial path.
- R10: With `sda_dly`=0 the serial SDA path has no delay. With `div_sel`=0 and `sda_dly`=N>0, a change of the serial SDA value appears on `sda_oe` after exactly N rising clock edges.
- R11: The filter clock ticks once every D = 2^`div_sel` cycles (`div_sel` 0..3 gives divide by 1, 2, 4, 8). A serial SDA change appears after between (N-1)·D+1 and N·D rising edges.
- R12: While `bit_nine`=1, the serial SDA path carries the acknowledge setting instead of `sh_sda`. `ack_nack_tx`=0 pulls SDA low (ACK) and 1 releases it (NACK, letting the slave answer).
- R13: On a rising edge of `scl_in` while `bit_nine`=1, `sda_in` is stored in `ack_rx` (0 = ACK, 1 = NACK). Rising edges with `bit_nine`=0 leave `ack_rx` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start condition request strobe |
| restart_req | input | 1 | Repeated-start request strobe |
| stop_req | input | 1 | Stop condition request strobe |
| done_clr | input | 1 | Software clear of the completion flag |
| sda_sel | input | 2 | SDA source select |
| scl_sel | input | 2 | SCL source select |
| sda_dly | input | 5 | SDA output delay in filter-clock ticks |
| ack_nack_tx | input | 1 | 0 sends ACK, 1 sends NACK on the ninth clock |
| div_sel | input | 2 | Filter clock divide select |
| half_period | input | 8 | Phase length in clock cycles |
| sh_sda | input | 1 | Shifter serial data (1 = released) |
| sh_scl | input | 1 | Shifter serial clock level |
| bit_nine | input | 1 | Shifter is in the ninth (acknowledge) bit |
| sda_in | input | 1 | Sampled SDA line |
| scl_in | input | 1 | Sampled SCL line |
| sda_oe | output | 1 | SDA pull-low enable |
| scl_oe | output | 1 | SCL pull-low enable |
| done_flag | output | 1 | Condition generation complete (sticky) |
| ack_rx | output | 1 | Acknowledge bit captured on the ninth clock |

## Verification
The assertions watch four things on every cycle:
- the completion flag only rises as a final phase ends and only falls on a clear or a new request;
- a phase never moves on before its counter expires;
- the forced-low and released selector codes always win over other sources;
- the captured acknowledge bit only changes on a qualified ninth-clock SCL edge.

The order and duration of the line levels within each condition, the delay windows under each divider setting, request priority and the ignoring of requests while busy are only visible through the bench's timed scenarios, which compare the pads against a phase model cycle by cycle.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [1:0] {
        SEL_SERIAL = 2'b00,
        SEL_COND   = 2'b01,
        SEL_LOW    = 2'b10,
        SEL_HIZ    = 2'b11
    } line_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RS_SDA_REL,
        ST_RS_SCL_REL,
        ST_ST_SDA_LOW,
        ST_ST_SCL_LOW,
        ST_SP_SCL_REL,
        ST_SP_SDA_REL
    } cond_state_e;

    typedef struct packed {
        logic sda_lo;
        logic scl_lo;
    } line_pair_t;

    // Pull-low levels held on the lines during each phase
    function automatic line_pair_t phase_levels(cond_state_e s);
        line_pair_t lv;
        case (s)
            ST_RS_SDA_REL: lv = '{sda_lo: 1'b0, scl_lo: 1'b1};
            ST_RS_SCL_REL: lv = '{sda_lo: 1'b0, scl_lo: 1'b0};
            ST_ST_SDA_LOW: lv = '{sda_lo: 1'b1, scl_lo: 1'b0};
            ST_ST_SCL_LOW: lv = '{sda_lo: 1'b1, scl_lo: 1'b1};
            ST_SP_SCL_REL: lv = '{sda_lo: 1'b1, scl_lo: 1'b0};
            ST_SP_SDA_REL: lv = '{sda_lo: 1'b0, scl_lo: 1'b0};
            default:       lv = '{sda_lo: 1'b0, scl_lo: 1'b0};
        endcase
        return lv;
    endfunction

    // Phase that follows the given one; a restart chains into a start
    function automatic cond_state_e next_phase(cond_state_e s);
        case (s)
            ST_RS_SDA_REL: return ST_RS_SCL_REL;
            ST_RS_SCL_REL: return ST_ST_SDA_LOW;
            ST_ST_SDA_LOW: return ST_ST_SCL_LOW;
            ST_SP_SCL_REL: return ST_SP_SDA_REL;
            default:       return ST_IDLE;
        endcase
    endfunction

    // Four-way source mux for one line (1 = pull low)
    function automatic logic line_drive(line_sel_e sel, logic serial_lo, logic cond_lo);
        case (sel)
            SEL_SERIAL: return serial_lo;
            SEL_COND:   return cond_lo;
            SEL_LOW:    return 1'b1;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/i2c_tick_div.sv
module i2c_tick_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   one_sh;
    logic [CNT_W:0]   mask_full;

    assign one_sh    = {{CNT_W{1'b0}}, 1'b1} << div_sel;
    assign mask_full = one_sh - {{CNT_W{1'b0}}, 1'b1};
    assign tick      = (cnt & mask_full[CNT_W-1:0]) == mask_full[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_sda_delay.sv
module i2c_sda_delay #(
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [DLY_W-1:0] dly,
    input  logic             din,
    output logic             dout
);
    localparam int TAPS = (1 << DLY_W) - 1;

    logic [TAPS-1:0] taps;

    always_ff @(posedge clk) begin
        if (rst)       taps <= '0;
        else if (tick) taps <= {taps[TAPS-2:0], din};
    end

    assign dout = (dly == '0) ? din : taps[dly - DLY_W'(1)];
endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
    import i2c_cond_pkg::*;
#(
    parameter int HP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_req,
    input  logic            restart_req,
    input  logic            stop_req,
    input  logic            done_clr,
    input  logic [HP_W-1:0] half_period,
    output logic            gen_sda_lo,
    output logic            gen_scl_lo,
    output logic            done_flag
);
    cond_state_e     state;
    cond_state_e     first_phase;
    cond_state_e     nxt;
    line_pair_t      lines;
    logic [HP_W-1:0] cnt;
    logic [HP_W-1:0] hp_eff;
    logic            accept;

    assign hp_eff = (half_period == '0) ? HP_W'(1) : half_period;
    assign accept = (state == ST_IDLE) && (start_req || restart_req || stop_req);
    assign nxt    = next_phase(state);

    always_comb begin
        if (start_req)        first_phase = ST_ST_SDA_LOW;
        else if (restart_req) first_phase = ST_RS_SDA_REL;
        else                  first_phase = ST_SP_SCL_REL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            lines     <= '0;
            done_flag <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (accept) begin
                state     <= first_phase;
                lines     <= phase_levels(first_phase);
                cnt       <= hp_eff - HP_W'(1);
                done_flag <= 1'b0;
            end else if (done_clr) begin
                done_flag <= 1'b0;
            end
        end else if (cnt == '0) begin
            state <= nxt;
            cnt   <= hp_eff - HP_W'(1);
            if (nxt == ST_IDLE) done_flag <= 1'b1;
            else                lines     <= phase_levels(nxt);
        end else begin
            cnt <= cnt - HP_W'(1);
        end
    end

    assign gen_sda_lo = lines.sda_lo;
    assign gen_scl_lo = lines.scl_lo;

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> ($past(state) == ST_ST_SCL_LOW || $past(state) == ST_SP_SDA_REL));
    // R6
    done_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done_flag) |-> ($past(done_clr) || $past(accept)));
    // R6
    busy_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> !done_flag);
    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && cnt != '0) |=> (state == $past(state)));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !accept) |=> $stable(lines));
endmodule

// File: rtl/i2c_ack_sample.sv
module i2c_ack_sample (
    input  logic clk,
    input  logic rst,
    input  logic bit_nine,
    input  logic scl_in,
    input  logic sda_in,
    output logic ack_rx
);
    logic scl_prev;
    logic scl_rise;

    assign scl_rise = scl_in && !scl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            ack_rx   <= 1'b0;
        end else begin
            scl_prev <= scl_in;
            if (scl_rise && bit_nine) ack_rx <= sda_in;
        end
    end

    // R13
    ack_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ack_rx) |-> $past(bit_nine && scl_in && !scl_prev));
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int DLY_W     = 5,
    parameter int HP_W      = 8,
    parameter int DIV_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_req,
    input  logic                 restart_req,
    input  logic                 stop_req,
    input  logic                 done_clr,
    input  logic [1:0]           sda_sel,
    input  logic [1:0]           scl_sel,
    input  logic [DLY_W-1:0]     sda_dly,
    input  logic                 ack_nack_tx,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic [HP_W-1:0]      half_period,
    input  logic                 sh_sda,
    input  logic                 sh_scl,
    input  logic                 bit_nine,
    input  logic                 sda_in,
    input  logic                 scl_in,
    output logic                 sda_oe,
    output logic                 scl_oe,
    output logic                 done_flag,
    output logic                 ack_rx
);
    logic filt_tick;
    logic ser_sda_raw;
    logic ser_sda_dly;
    logic gen_sda_lo;
    logic gen_scl_lo;

    // Acknowledge override on the ninth bit, then the delay line
    assign ser_sda_raw = bit_nine ? !ack_nack_tx : !sh_sda;

    i2c_tick_div #(.SEL_W(DIV_SEL_W)) u_div (
        .clk(clk), .rst(rst), .div_sel(div_sel), .tick(filt_tick)
    );

    i2c_sda_delay #(.DLY_W(DLY_W)) u_dly (
        .clk(clk), .rst(rst), .tick(filt_tick), .dly(sda_dly),
        .din(ser_sda_raw), .dout(ser_sda_dly)
    );

    i2c_cond_fsm #(.HP_W(HP_W)) u_fsm (
        .clk(clk), .rst(rst), .start_req(start_req), .restart_req(restart_req),
        .stop_req(stop_req), .done_clr(done_clr), .half_period(half_period),
        .gen_sda_lo(gen_sda_lo), .gen_scl_lo(gen_scl_lo), .done_flag(done_flag)
    );

    i2c_ack_sample u_ack (
        .clk(clk), .rst(rst), .bit_nine(bit_nine), .scl_in(scl_in),
        .sda_in(sda_in), .ack_rx(ack_rx)
    );

    assign sda_oe = line_drive(line_sel_e'(sda_sel), ser_sda_dly, gen_sda_lo);
    assign scl_oe = line_drive(line_sel_e'(scl_sel), !sh_scl, gen_scl_lo);

    // R8
    sda_forced_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_sel == 2'b10 |-> sda_oe) and (sda_sel == 2'b11 |-> !sda_oe));
    // R9
    scl_forced_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_sel == 2'b10 |-> scl_oe) and (scl_sel == 2'b11 |-> !scl_oe));
endmodule

// File: tb/i2c_cond_gen_tb.sv
`timescale 1ns/1ps
module i2c_cond_gen_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_req, restart_req, stop_req, done_clr;
    logic [1:0] sda_sel, scl_sel;
    logic [4:0] sda_dly;
    logic       ack_nack_tx;
    logic [1:0] div_sel;
    logic [7:0] half_period;
    logic       sh_sda, sh_scl, bit_nine, sda_in, scl_in;
    logic       sda_oe, scl_oe, done_flag, ack_rx;

    int checks = 0;
    int errors = 0;
    logic gen_sda = 1'b0;
    logic gen_scl = 1'b0;

    always #2.5 clk = ~clk;

    i2c_cond_gen u_dut (
        .clk(clk), .rst(rst), .start_req(start_req), .restart_req(restart_req),
        .stop_req(stop_req), .done_clr(done_clr), .sda_sel(sda_sel), .scl_sel(scl_sel),
        .sda_dly(sda_dly), .ack_nack_tx(ack_nack_tx), .div_sel(div_sel),
        .half_period(half_period), .sh_sda(sh_sda), .sh_scl(sh_scl), .bit_nine(bit_nine),
        .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .done_flag(done_flag), .ack_rx(ack_rx)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // kind: 0 start, 1 restart, 2 stop; returns {sda_lo, scl_lo}
    function automatic logic [1:0] exp_phase(int kind, int p);
        if (kind == 0) return (p == 0) ? 2'b10 : 2'b11;
        if (kind == 2) return (p == 0) ? 2'b10 : 2'b00;
        case (p)
            0: return 2'b01;
            1: return 2'b00;
            2: return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    function automatic int n_phases(int kind);
        return (kind == 1) ? 4 : 2;
    endfunction

    function automatic logic exp_line(logic [1:0] sel, logic ser_lo, logic gen_lo);
        case (sel)
            2'b00: return ser_lo;
            2'b01: return gen_lo;
            2'b10: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // disturb: request another condition mid-sequence; both: add stop alongside
    // clr_end: pulse done_clr on the completion edge
    task automatic run_cond(int kind, int hp, bit disturb, bit both, bit clr_end);
        int hpe;
        int n;
        string tag;
        logic [1:0] e;
        hpe = (hp == 0) ? 1 : hp;
        n = n_phases(kind);
        tag = (kind == 0) ? "R2" : (kind == 1) ? "R4" : "R3";
        if (hp == 0) tag = {tag, "/R5"};
        if (disturb || both) tag = {tag, "/R7"};
        @(negedge clk);
        sda_sel = 2'b01; scl_sel = 2'b01; half_period = 8'(hp);
        start_req = (kind == 0); restart_req = (kind == 1);
        stop_req = (kind == 2) || both;
        @(negedge clk);
        start_req = 0; restart_req = 0; stop_req = 0;
        for (int j = 1; j <= n * hpe + 3; j++) begin
            int p;
            p = (j - 1) / hpe;
            e = exp_phase(kind, (p < n) ? p : n - 1);
            chk({tag, " sda"}, int'(sda_oe), int'(e[1]));
            chk({tag, " scl"}, int'(scl_oe), int'(e[0]));
            chk(clr_end ? "R6 set-wins" : "R6 done", int'(done_flag), int'(p >= n));
            start_req = 0; stop_req = 0; done_clr = 0;
            if (disturb && j == 2) begin
                if (kind == 2) start_req = 1; else stop_req = 1;
            end
            if (clr_end && j == n * hpe) done_clr = 1;
            @(negedge clk);
        end
        done_clr = 0;
        gen_sda = e[1]; gen_scl = e[0];
    endtask

    task automatic run_dly(int n, int s);
        int ev;
        int d;
        d = 1 << s;
        sda_sel = 2'b00; bit_nine = 0; sda_dly = 5'(n); div_sel = 2'(s); sh_sda = 1;
        repeat (260) @(negedge clk);
        chk("R10 settled", int'(sda_oe), 0);
        sh_sda = 0;
        if (n == 0) begin
            #1 chk("R10 no delay", int'(sda_oe), 1);
        end else begin
            ev = 0;
            while (ev < 300) begin
                @(negedge clk);
                ev++;
                if (sda_oe) break;
            end
            if (s == 0) chk("R10 delay edges", ev, n);
            else begin
                checks++;
                if (ev < (n - 1) * d + 1 || ev > n * d) begin
                    errors++;
                    $display("FAIL R11 actual=%0d expected=%0d..%0d", ev, (n - 1) * d + 1, n * d);
                end
            end
        end
        sh_sda = 1;
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        rst = 1; start_req = 0; restart_req = 0; stop_req = 0; done_clr = 0;
        sda_sel = 2'b01; scl_sel = 2'b01; sda_dly = 0; ack_nack_tx = 0; div_sel = 0;
        half_period = 2; sh_sda = 1; sh_scl = 1; bit_nine = 0; sda_in = 1; scl_in = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 scl_oe", int'(scl_oe), 0);
        chk("R1 done", int'(done_flag), 0);
        chk("R1 ack_rx", int'(ack_rx), 0);

        // Directed sequences
        run_cond(0, 3, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R6 sticky", int'(done_flag), 1);
        chk("R2 held", int'(scl_oe), 1);
        done_clr = 1; @(negedge clk); done_clr = 0;
        chk("R6 cleared", int'(done_flag), 0);
        run_cond(2, 2, 0, 0, 0);
        run_cond(1, 1, 0, 0, 0);
        run_cond(0, 0, 0, 0, 0);
        run_cond(2, 4, 1, 0, 0);
        run_cond(0, 4, 1, 0, 0);
        run_cond(0, 2, 0, 1, 0);
        run_cond(2, 1, 0, 0, 1);
        repeat (2) @(negedge clk);
        chk("R6 set-wins hold", int'(done_flag), 1);
        for (int i = 0; i < 6; i++)
            run_cond($urandom_range(0, 2), $urandom_range(0, 6), 0, 0, 0);

        // Line selectors, random
        for (int i = 0; i < 40; i++) begin
            sda_sel = 2'($urandom_range(0, 3)); scl_sel = 2'($urandom_range(0, 3));
            sh_sda = 1'($urandom_range(0, 1)); sh_scl = 1'($urandom_range(0, 1));
            sda_dly = 0; bit_nine = 0;
            #1;
            chk("R8 sda select", int'(sda_oe), int'(exp_line(sda_sel, !sh_sda, gen_sda)));
            chk("R9 scl select", int'(scl_oe), int'(exp_line(scl_sel, !sh_scl, gen_scl)));
            @(negedge clk);
        end

        // Acknowledge drive
        sda_sel = 2'b00; sda_dly = 0; bit_nine = 1;
        for (int i = 0; i < 6; i++) begin
            ack_nack_tx = 1'(i % 2); sh_sda = 1'($urandom_range(0, 1));
            #1 chk("R12 ack drive", int'(sda_oe), int'(!ack_nack_tx));
            @(negedge clk);
        end

        // Acknowledge capture
        scl_in = 0; sda_in = 1; @(negedge clk);
        scl_in = 1; @(negedge clk);
        chk("R13 nack captured", int'(ack_rx), 1);
        scl_in = 0; sda_in = 0; @(negedge clk);
        scl_in = 1; @(negedge clk);
        chk("R13 ack captured", int'(ack_rx), 0);
        bit_nine = 0; scl_in = 0; sda_in = 1; @(negedge clk);
        scl_in = 1; @(negedge clk);
        chk("R13 ignored outside ninth", int'(ack_rx), 0);

        // Delay line
        run_dly(0, 0);
        run_dly(1, 0);
        run_dly(3, 0);
        run_dly(31, 0);
        run_dly(4, 3);
        run_dly(1, 1);
        for (int i = 0; i < 6; i++)
            run_dly($urandom_range(1, 20), $urandom_range(0, 3));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule